// File: doc/BRIEF.md
# Bus Reset and PS/2 Activity Detector

This block watches the two lines of a low-speed USB port and the data line of a PS/2 port, and raises a single shared interrupt request once the watched bus condition has lasted long enough. A mode input picks the watched condition. In USB mode the condition is a single-ended zero, with both D+ and D- low. In PS/2 mode the condition is the data line held low. The lines are judged only at a periodic 128 µs strobe that a free-running timer outside the block provides. The block therefore needs no counter of its own at system-clock resolution.

A condition counts as qualified once enough consecutive strobes have seen it. With the default of two strobes, detection comes 128 to 256 µs after the condition starts. In USB mode the event is raised at the first strobe that finds the single-ended zero gone. In PS/2 mode the event is raised at the strobe that qualifies the low. While a qualified condition is present, the block drives a clear to the device address register. Events set a sticky pending flag that software clears with a pulse. The interrupt request is the pending flag gated by an enable.

Top module: `busrst_ps2_det`

## Requirements
- R1: With `mode_sel`=0 (USB mode), the watched condition is `usb_dp`=0 and `usb_dm`=0 together. A single low line does not count, and `ps2_data` has no effect.
- R2: With `mode_sel`=1 (PS/2 mode), the watched condition is `ps2_data`=0. `usb_dp` and `usb_dm` have no effect.
- R3: In USB mode, once the condition is qualified, the pending flag is set at the first tick that finds the condition absent. It is not set at the tick that qualifies the condition.
- R4: In PS/2 mode, the pending flag is set at the tick that qualifies the condition. No further event occurs while the low is held.
- R5: The condition qualifies after QUAL_TICKS (default 2) consecutive ticks that each see it present. A tick that sees it absent restarts the count. Only ticks advance the count.
- R6: `addr_clr` is 1 from the qualifying tick until the tick that finds the condition absent, and 0 at all other times.
- R7: `irq` equals the pending flag ANDed with `irq_en`. The pending flag latches events whatever the value of `irq_en`.
- R8: The pending flag stays set until a `pend_clr` pulse. If an event and `pend_clr` fall in the same cycle, the flag ends set.
- R9: A change of `mode_sel` restarts qualification. It drops `addr_clr` on the next clock and raises no event.
- R10: After reset, `irq`, `pending` and `addr_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe every 128 µs from the free-running timer |
| mode_sel | input | 1 | 0 = USB single-ended-zero detection, 1 = PS/2 activity detection |
| usb_dp | input | 1 | USB D+ line, asynchronous |
| usb_dm | input | 1 | USB D- line, asynchronous |
| ps2_data | input | 1 | PS/2 data line, asynchronous |
| irq_en | input | 1 | Interrupt enable, 1 = enabled |
| pend_clr | input | 1 | One-cycle software clear of the pending flag |
| irq | output | 1 | Interrupt request |
| pending | output | 1 | Sticky pending flag |
| addr_clr | output | 1 | Clear to the device address register |

## Verification
The event that sets the pending flag and the software clear of that flag can land on the same clock edge. The bench provokes this by asserting `pend_clr` in the cycle of the tick that ends a qualified single-ended zero. It then requires the flag to read 1 afterwards, so the event must win. A second scenario clears the flag between two ticks while a PS/2 low is held. The flag must stay 0 across the following tick, which shows that the set path fires only once per qualified condition.

// File: rtl/bdet_pkg.sv
package bdet_pkg;

    typedef enum logic {
        MODE_USB = 1'b0,
        MODE_PS2 = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic dp;
        logic dm;
        logic ps2;
    } line_s;

    localparam int LINE_W = $bits(line_s);

    typedef struct packed {
        logic qualified;
        logic rise;
        logic fall;
    } qual_s;

    function automatic logic cond_of(det_mode_e m, line_s l);
        if (m == MODE_USB) begin
            return (!l.dp) && (!l.dm);
        end
        return !l.ps2;
    endfunction

endpackage

// File: rtl/bdet_sync.sv
module bdet_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RESET_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RESET_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bdet_qual.sv
module bdet_qual
    import bdet_pkg::*;
#(
    parameter int QUAL_TICKS = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  cond,
    input  logic  restart,
    output qual_s st
);
    localparam int CNT_W = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(QUAL_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (!cond)               cnt <= '0;
            else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        st.qualified = (cnt == CNT_TOP);
        st.rise      = tick && cond && !restart && (cnt == CNT_LAST);
        st.fall      = tick && !cond && !restart && (cnt == CNT_TOP);
    end

    // R5: count never passes its saturation value
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_TOP);

    // R5: only ticks move the count
    p_tick_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt));

    // R5: a tick seeing the condition absent restarts qualification
    p_absent_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cond) |=> (cnt == '0));

    // R9: restart leaves the condition unqualified
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        restart |=> !st.qualified);
endmodule

// File: rtl/bdet_event.sv
module bdet_event
    import bdet_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  det_mode_e mode,
    input  qual_s     st,
    input  logic      cond,
    output logic      ev,
    output logic      addr_clr
);
    always_comb begin
        unique case (mode)
            MODE_USB: ev = st.fall;
            MODE_PS2: ev = st.rise;
            default:  ev = 1'b0;
        endcase
        addr_clr = st.qualified;
    end

    // R3: USB events only come when the line pair has left SE0
    p_usb_release_r3: assert property (@(posedge clk) disable iff (rst)
        (ev && mode == MODE_USB) |-> !cond);

    // R4: a PS/2 event leaves the condition qualified
    p_ps2_qualify_r4: assert property (@(posedge clk) disable iff (rst)
        (ev && mode == MODE_PS2) |=> addr_clr);

    // R4: no PS/2 event while already qualified
    p_ps2_once_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PS2 && addr_clr) |-> !ev);
endmodule

// File: rtl/busrst_ps2_det.sv
module busrst_ps2_det
    import bdet_pkg::*;
#(
    parameter int QUAL_TICKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mode_sel,
    input  logic usb_dp,
    input  logic usb_dm,
    input  logic ps2_data,
    input  logic irq_en,
    input  logic pend_clr,
    output logic irq,
    output logic pending,
    output logic addr_clr
);
    line_s     raw_lines;
    line_s     lines;
    logic [LINE_W-1:0] sync_q;
    det_mode_e mode;
    det_mode_e mode_q;
    logic      mode_chg;
    logic      cond;
    qual_s     qst;
    logic      ev;
    logic      pend_q;

    assign raw_lines = '{dp: usb_dp, dm: usb_dm, ps2: ps2_data};

    bdet_sync #(
        .WIDTH     (LINE_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({LINE_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_q)
    );

    assign lines = line_s'(sync_q);
    assign mode  = det_mode_e'(mode_sel);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_USB;
        else     mode_q <= mode;
    end

    assign mode_chg = (mode != mode_q);
    assign cond     = cond_of(mode, lines);

    bdet_qual #(
        .QUAL_TICKS (QUAL_TICKS)
    ) u_qual (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cond    (cond),
        .restart (mode_chg),
        .st      (qst)
    );

    bdet_event u_event (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .st       (qst),
        .cond     (cond),
        .ev       (ev),
        .addr_clr (addr_clr)
    );

    always_ff @(posedge clk) begin
        if (rst)           pend_q <= 1'b0;
        else if (ev)       pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end

    assign pending = pend_q;
    assign irq     = pend_q && irq_en;

    // R8: an event wins over a same-cycle clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ev |=> pending);

    // R8: pending is sticky without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (pending && !pend_clr) |=> pending);

    // R9: a mode change never raises an event
    p_mode_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        mode_chg |-> !ev);

    // R10: outputs idle in the cycle after reset
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!pending && !addr_clr));
endmodule

// File: tb/busrst_ps2_det_bench.sv
module busrst_ps2_det_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst, tick, mode_sel, usb_dp, usb_dm, ps2_data, irq_en, pend_clr;
    logic irq, pending, addr_clr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busrst_ps2_det u_busrst_ps2_det (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode_sel (mode_sel),
        .usb_dp   (usb_dp),
        .usb_dm   (usb_dm),
        .ps2_data (ps2_data),
        .irq_en   (irq_en),
        .pend_clr (pend_clr),
        .irq      (irq),
        .pending  (pending),
        .addr_clr (addr_clr)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_lines(input logic dp, input logic dm, input logic p2);
        @(negedge clk);
        usb_dp = dp; usb_dm = dm; ps2_data = p2;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_pend();
        @(negedge clk) pend_clr = 1'b1;
        @(negedge clk) pend_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 1'b0; mode_sel = 1'b0; irq_en = 1'b1; pend_clr = 1'b0;
        usb_dp = 1'b0; usb_dm = 1'b1; ps2_data = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(irq, 1'b0, "R10 irq after reset");
        check(pending, 1'b0, "R10 pending after reset");
        check(addr_clr, 1'b0, "R10 addr_clr after reset");
    endtask

    task automatic t_usb_reset();
        mode_sel = 1'b0;
        set_lines(1'b0, 1'b0, 1'b1);
        do_tick();
        check(addr_clr, 1'b0, "R5 one tick not qualified");
        do_tick();
        check(addr_clr, 1'b1, "R6 addr_clr at qualifying tick");
        check(pending, 1'b0, "R3 no event at qualification");
        do_tick();
        check(addr_clr, 1'b1, "R6 addr_clr held during SE0");
        set_lines(1'b0, 1'b1, 1'b1);
        check(pending, 1'b0, "R3 no event before tick");
        do_tick();
        check(pending, 1'b1, "R3 event at release tick");
        check(irq, 1'b1, "R7 irq with enable");
        check(addr_clr, 1'b0, "R6 addr_clr drops at release");
        do_tick();
        check(pending, 1'b1, "R8 pending sticky");
        clear_pend();
        check(pending, 1'b0, "R8 pending cleared");
    endtask

    task automatic t_usb_short_and_single();
        mode_sel = 1'b0;
        set_lines(1'b0, 1'b0, 1'b1);
        do_tick();
        set_lines(1'b0, 1'b1, 1'b1);
        do_tick();
        set_lines(1'b0, 1'b0, 1'b1);
        do_tick();
        check(addr_clr, 1'b0, "R5 interrupted SE0 restarts count");
        set_lines(1'b0, 1'b1, 1'b1);
        do_tick();
        check(pending, 1'b0, "R5 short SE0 no event");
        set_lines(1'b1, 1'b0, 1'b1);
        do_tick(); do_tick(); do_tick();
        check(addr_clr, 1'b0, "R1 D- low alone not SE0");
        set_lines(1'b1, 1'b1, 1'b0);
        do_tick(); do_tick(); do_tick();
        check(addr_clr, 1'b0, "R1 ps2 low ignored in USB mode");
        set_lines(1'b0, 1'b1, 1'b1);
        do_tick();
        check(pending, 1'b0, "R1 no event from ignored lines");
    endtask

    task automatic t_ps2();
        mode_sel = 1'b1;
        repeat (2) @(negedge clk);
        set_lines(1'b0, 1'b0, 1'b1);
        do_tick(); do_tick(); do_tick();
        check(addr_clr, 1'b0, "R2 SE0 ignored in PS/2 mode");
        check(pending, 1'b0, "R2 no event from SE0");
        set_lines(1'b0, 1'b1, 1'b0);
        do_tick();
        check(pending, 1'b0, "R4 not yet qualified");
        do_tick();
        check(pending, 1'b1, "R4 event at qualifying tick");
        check(addr_clr, 1'b1, "R6 addr_clr in PS/2 low");
        clear_pend();
        do_tick();
        check(pending, 1'b0, "R4 no re-fire while low held");
        set_lines(1'b0, 1'b1, 1'b1);
        do_tick();
        check(addr_clr, 1'b0, "R6 addr_clr drops after PS/2 low");
        check(pending, 1'b0, "R4 no event on PS/2 release");
    endtask

    task automatic t_enable();
        mode_sel = 1'b1;
        irq_en = 1'b0;
        set_lines(1'b0, 1'b1, 1'b0);
        do_tick(); do_tick();
        check(pending, 1'b1, "R7 pending latched when disabled");
        check(irq, 1'b0, "R7 irq gated off");
        @(negedge clk) irq_en = 1'b1;
        @(negedge clk);
        check(irq, 1'b1, "R7 irq follows enable");
        set_lines(1'b0, 1'b1, 1'b1);
        do_tick();
        clear_pend();
    endtask

    task automatic t_same_cycle();
        mode_sel = 1'b0;
        repeat (2) @(negedge clk);
        set_lines(1'b0, 1'b0, 1'b1);
        do_tick(); do_tick();
        set_lines(1'b0, 1'b1, 1'b1);
        @(negedge clk) begin tick = 1'b1; pend_clr = 1'b1; end
        @(negedge clk) begin tick = 1'b0; pend_clr = 1'b0; end
        check(pending, 1'b1, "R8 event wins over same-cycle clear");
        clear_pend();
    endtask

    task automatic t_mode_change();
        mode_sel = 1'b0;
        set_lines(1'b0, 1'b0, 1'b1);
        do_tick(); do_tick();
        check(addr_clr, 1'b1, "R9 qualified before mode change");
        @(negedge clk) mode_sel = 1'b1;
        @(negedge clk);
        check(addr_clr, 1'b0, "R9 mode change drops addr_clr");
        check(pending, 1'b0, "R9 mode change no event");
        do_tick();
        check(pending, 1'b0, "R9 no event after mode change");
        mode_sel = 1'b0;
        set_lines(1'b0, 1'b1, 1'b1);
        do_tick();
        check(pending, 1'b0, "R9 no late USB event");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_usb_reset();
        t_usb_short_and_single();
        t_ps2();
        t_enable();
        t_same_cycle();
        t_mode_change();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule